// File: doc/BRIEF.md
# DRAM Refresh and Wake-Up Sequencer

This block keeps an EDO DRAM alive without driving any row address. After an active-low reset it holds the memory idle for a programmable power-up pause. It then runs a burst of wake-up cycles and from that point issues CAS-before-RAS refresh cycles at a fixed interval, so that every row is refreshed inside the retention window. The device counts rows internally, so the block only has to deliver the right number of refresh cycles in the right order.

The block shares the memory strobes with a normal access path. When it needs a refresh it raises a request to an access arbiter and waits for a grant. It then owns RAS and all byte-lane CAS strobes for one complete refresh cycle, including precharge, and releases them together with the request. A ready output tells the access path when normal traffic may run. If the arbiter starves the refresher for too many intervals, ready falls and the wake-up burst is run again before ready returns.

All lengths are parameters counted in clock cycles: the pause, the refresh interval, the wake-up count, the overdue limit and the four phases of a refresh cycle.

Top module: `dref_seq`

## Requirements
- R1: While reset is asserted and until the first request, `refresh_req`, `strobe_own` and `ready` are 0, and `ras_n` and every bit of `cas_n` are 1.
- R2: After reset is released no request is raised during the PAUSE_CYC-cycle pause. The first request becomes visible in cycle PAUSE_CYC+1, counting the first clock edge after release as cycle 1.
- R3: After the pause, exactly WAKE_CNT complete refresh cycles are run with `ready` at 0. `ready` rises at the clock edge that ends the last of them.
- R4: In every refresh cycle all CAS lanes move together. `cas_n[0]` is the lower byte lane and `cas_n[1]` the upper one. All lanes are low for CSR_CYC cycles before `ras_n` falls. `ras_n` then stays low for RAS_LO_CYC cycles, and the lanes stay low for the first CHR_CYC of those cycles.
- R5: After `ras_n` rises, all strobes stay high for RP_CYC cycles of precharge. `strobe_own` falls at the end of that precharge.
- R6: While `ready` is 1 and grants come promptly, a new request rises every INTERVAL_CYC cycles.
- R7: A request stays high until granted. The refresh cycle starts at the clock edge that samples the grant. The request and `strobe_own` both fall at the edge that ends the precharge, so the request lasts grant delay + 1 + CSR_CYC + RAS_LO_CYC + RP_CYC cycles.
- R8: When a request is still waiting as the MISS_LIMIT-th interval after it expires, `ready` falls at that edge, which is MISS_LIMIT*INTERVAL_CYC cycles after the request rose. WAKE_CNT new wake-up cycles then run before `ready` rises again.
- R9: Fewer than MISS_LIMIT missed intervals leave `ready` high. A completed refresh clears the missed-interval count.
- R10: A grant while no request is pending starts nothing: `strobe_own` stays 0 and all strobes stay high.
- R11: Whenever `strobe_own` is 0, `ras_n` and all CAS lanes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| refresh_grant | input | 1 | Arbiter grant for the pending refresh |
| refresh_req | output | 1 | Refresh request to the arbiter |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | NCAS | Byte-lane column strobes, active low, bit 0 is the lower lane |
| strobe_own | output | 1 | Block currently drives the strobes |
| ready | output | 1 | Normal accesses allowed |

## Verification
The refresh path is driven with a one-cycle grant latency through the wake-up burst and steady running, and with a six-cycle latency. The steady-running case shows that the interval timer sets the request rate. The longer latency separates a request that waits correctly for its grant from one that starts or ends on its own. Grants are also withheld for one interval twice in a row and then for two intervals. This tells apart a miss count that is cleared by each completed refresh from one that only accumulates, and pins the exact edge at which ready falls. A spurious grant with no request confirms that the strobes cannot be taken without a pending request.

// File: rtl/dref_pkg.sv
package dref_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_RASLO,
    PH_PRECH
  } cbr_ph_t;

  typedef enum logic [1:0] {
    SQ_PAUSE,
    SQ_WAKE,
    SQ_RUN
  } seq_st_t;

endpackage

// File: rtl/dref_span.sv
module dref_span #(
  parameter int SPAN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic last
);

  localparam int CW = (SPAN > 1) ? $clog2(SPAN) : 1;
  localparam logic [CW-1:0] LAST_V = CW'(SPAN - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign last = (cnt_q == LAST_V);

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (en) begin
      cnt_d = last ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/dref_budget.sv
module dref_budget #(
  parameter int LIMIT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic miss,
  input  logic clear,
  output logic broken
);

  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] EDGE_V = CW'(LIMIT - 1);

  logic [CW-1:0] ovd_q, ovd_d;

  assign broken = miss && (ovd_q == EDGE_V);

  always_comb begin
    ovd_d = ovd_q;
    if (clear || broken) begin
      ovd_d = '0;
    end else if (miss) begin
      ovd_d = ovd_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovd_q <= '0;
    end else begin
      ovd_q <= ovd_d;
    end
  end

endmodule

// File: rtl/dref_cbr.sv
module dref_cbr
  import dref_pkg::*;
#(
  parameter int CSR_CYC    = 2,
  parameter int RAS_LO_CYC = 6,
  parameter int CHR_CYC    = 2,
  parameter int RP_CYC     = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic ras_n,
  output logic cas_n,
  output logic busy,
  output logic done
);

  localparam int MAX_A = (CSR_CYC > RAS_LO_CYC) ? CSR_CYC : RAS_LO_CYC;
  localparam int MAXP  = (MAX_A > RP_CYC) ? MAX_A : RP_CYC;
  localparam int CW    = $clog2(MAXP + 1);
  localparam logic [CW-1:0] CHR_V = CW'(CHR_CYC);

  cbr_ph_t       ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] lim;
  logic          last;

  always_comb begin
    case (ph_q)
      PH_SETUP: lim = CW'(CSR_CYC - 1);
      PH_RASLO: lim = CW'(RAS_LO_CYC - 1);
      PH_PRECH: lim = CW'(RP_CYC - 1);
      default:  lim = '0;
    endcase
  end

  assign last = (cnt_q == lim);

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    if (ph_q == PH_IDLE) begin
      cnt_d = '0;
      if (start) ph_d = PH_SETUP;
    end else if (last) begin
      cnt_d = '0;
      case (ph_q)
        PH_SETUP: ph_d = PH_RASLO;
        PH_RASLO: ph_d = PH_PRECH;
        default:  ph_d = PH_IDLE;
      endcase
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign busy  = (ph_q != PH_IDLE);
  assign ras_n = (ph_q != PH_RASLO);
  assign cas_n = !((ph_q == PH_SETUP) || ((ph_q == PH_RASLO) && (cnt_q < CHR_V)));
  assign done  = (ph_q == PH_PRECH) && last;

endmodule

// File: rtl/dref_seq.sv
module dref_seq
  import dref_pkg::*;
#(
  parameter int NCAS         = 2,
  parameter int PAUSE_CYC    = 40000,
  parameter int INTERVAL_CYC = 3000,
  parameter int WAKE_CNT     = 8,
  parameter int MISS_LIMIT   = 2,
  parameter int CSR_CYC      = 2,
  parameter int RAS_LO_CYC   = 6,
  parameter int CHR_CYC      = 2,
  parameter int RP_CYC       = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            refresh_grant,
  output logic            refresh_req,
  output logic            ras_n,
  output logic [NCAS-1:0] cas_n,
  output logic            strobe_own,
  output logic            ready
);

  seq_st_t st_q, st_d;
  logic    pend_q, pend_d;
  logic    pause_last, wake_last, int_last;
  logic    tick, start, miss, broken;
  logic    busy, done, cyc_cas_n;

  // Refresh cycle engine
  dref_cbr #(
    .CSR_CYC    (CSR_CYC),
    .RAS_LO_CYC (RAS_LO_CYC),
    .CHR_CYC    (CHR_CYC),
    .RP_CYC     (RP_CYC)
  ) cbr_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .ras_n (ras_n),
    .cas_n (cyc_cas_n),
    .busy  (busy),
    .done  (done)
  );

  // Power-up pause length
  dref_span #(.SPAN(PAUSE_CYC)) pause_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (st_q != SQ_PAUSE),
    .en    (st_q == SQ_PAUSE),
    .last  (pause_last)
  );

  // Wake-up burst: counts completed cycles
  dref_span #(.SPAN(WAKE_CNT)) wake_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (st_q != SQ_WAKE),
    .en    ((st_q == SQ_WAKE) && done),
    .last  (wake_last)
  );

  // Steady refresh interval
  dref_span #(.SPAN(INTERVAL_CYC)) intv_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (st_q != SQ_RUN),
    .en    (st_q == SQ_RUN),
    .last  (int_last)
  );

  // Missed-interval accounting
  dref_budget #(.LIMIT(MISS_LIMIT)) budget_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .miss   (miss),
    .clear  (done),
    .broken (broken)
  );

  assign tick  = (st_q == SQ_RUN) && int_last;
  assign start = pend_q && refresh_grant && !busy;
  assign miss  = tick && pend_q && !start;

  always_comb begin
    st_d   = st_q;
    pend_d = pend_q;
    if (start) pend_d = 1'b0;
    case (st_q)
      SQ_PAUSE: begin
        if (pause_last) st_d = SQ_WAKE;
      end
      SQ_WAKE: begin
        if (!pend_q && !busy) pend_d = 1'b1;
        if (done && wake_last) st_d = SQ_RUN;
      end
      SQ_RUN: begin
        if (tick) pend_d = 1'b1;
        if (broken) st_d = SQ_WAKE;
      end
      default: st_d = SQ_PAUSE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_PAUSE;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
    end
  end

  // All byte lanes share one column strobe timing
  for (genvar g = 0; g < NCAS; g++) begin : g_lane
    assign cas_n[g] = cyc_cas_n;
  end

  assign refresh_req = pend_q || busy;
  assign strobe_own  = busy;
  assign ready       = (st_q == SQ_RUN);

endmodule

// File: rtl/dref_seq_chk.sv
module dref_seq_chk #(
  parameter int NCAS = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            refresh_grant,
  input logic            refresh_req,
  input logic            ras_n,
  input logic [NCAS-1:0] cas_n,
  input logic            strobe_own,
  input logic            ready
);

  p_idle_strobes_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_own |-> (ras_n && (&cas_n)));

  p_cas_before_ras_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> ((cas_n == '0) && $past(cas_n == '0)));

  p_lanes_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_n == '0) || (&cas_n));

  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_req && !strobe_own && !refresh_grant) |=> refresh_req);

  p_own_needs_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_own) |-> $past(refresh_req && refresh_grant));

  p_release_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe_own) |-> ($past(ras_n && (&cas_n)) && !refresh_req));

  p_ready_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> (refresh_req && !strobe_own));

endmodule

bind dref_seq dref_seq_chk #(.NCAS(NCAS)) chk_i (.*);

// File: tb/dref_seq_tb_top.sv
`timescale 1ns/1ps
module dref_seq_tb_top;

  localparam int NC    = 2;
  localparam int PAUSE = 20;
  localparam int INTV  = 60;
  localparam int WAKE  = 8;
  localparam int MISS  = 2;
  localparam int CSR   = 2;
  localparam int RASL  = 5;
  localparam int CHR   = 3;
  localparam int RP    = 4;

  typedef struct {
    int csr;
    int ras;
    int chr;
    int rp;
  } rec_t;

  logic          clk;
  logic          rst_n;
  logic          grant;
  logic          req;
  logic          ras_n;
  logic [NC-1:0] cas_n;
  logic          own;
  logic          ready;

  int   checks;
  int   errors;
  rec_t exp_q[$];

  bit hold;
  int gnt_delay;

  int ncyc, rise_cnt, fall_cnt, first_rise, last_rise, req_start, req_width;
  int ready_rises, ready_falls, ready_fall_cyc, wake_recs;
  int m_csr, m_ras, m_chr, m_rp;
  bit seen_ras, lanes_bad;
  logic req_q, own_q, ready_q;

  dref_seq #(
    .NCAS(NC), .PAUSE_CYC(PAUSE), .INTERVAL_CYC(INTV), .WAKE_CNT(WAKE),
    .MISS_LIMIT(MISS), .CSR_CYC(CSR), .RAS_LO_CYC(RASL), .CHR_CYC(CHR), .RP_CYC(RP)
  ) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .refresh_grant (grant),
    .refresh_req   (req),
    .ras_n         (ras_n),
    .cas_n         (cas_n),
    .strobe_own    (own),
    .ready         (ready)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Arbiter model: grants a pending request after gnt_delay cycles
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && req && !own && !grant && !hold) begin
        repeat (gnt_delay - 1) @(negedge clk);
        if (req && !own && !hold) begin
          rec_t e;
          e.csr = CSR; e.ras = RASL; e.chr = CHR; e.rp = RP;
          exp_q.push_back(e);
          @(negedge clk);
          grant = 1'b1;
          @(negedge clk);
          grant = 1'b0;
        end
      end
    end
  end

  // Monitor: measures each refresh cycle and pin events
  initial begin
    req_q = 1'b0; own_q = 1'b0; ready_q = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        ncyc++;
        if (req && !req_q) begin
          rise_cnt++;
          last_rise = ncyc;
          req_start = ncyc;
          if (rise_cnt == 1) first_rise = ncyc;
        end
        if (!req && req_q) begin
          fall_cnt++;
          req_width = ncyc - req_start;
        end
        if (own) begin
          if (!((cas_n == '0) || (&cas_n))) lanes_bad = 1'b1;
          if (!ras_n) begin
            seen_ras = 1'b1;
            m_ras++;
            if (cas_n == '0) m_chr++;
          end else if (!seen_ras) begin
            if (cas_n == '0) m_csr++;
          end else begin
            if (&cas_n) m_rp++;
          end
        end
        if (!own && own_q) begin
          if (exp_q.size() == 0) begin
            chk("R7 cycle without grant", 1, 0);
          end else begin
            rec_t e;
            e = exp_q.pop_front();
            chk("R4 cas setup", m_csr, e.csr);
            chk("R4 ras low", m_ras, e.ras);
            chk("R4 cas hold", m_chr, e.chr);
            chk("R5 precharge", m_rp, e.rp);
            chk("R4 lanes equal", int'(lanes_bad), 0);
          end
          if (!ready_q) wake_recs++;
          m_csr = 0; m_ras = 0; m_chr = 0; m_rp = 0;
          seen_ras = 1'b0; lanes_bad = 1'b0;
        end
        if (ready && !ready_q) begin
          ready_rises++;
          chk("R3 wake cycles before ready", wake_recs, WAKE);
          wake_recs = 0;
        end
        if (!ready && ready_q) begin
          ready_falls++;
          ready_fall_cyc = ncyc;
        end
        req_q = req; own_q = own; ready_q = ready;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

  initial begin
    int n, a, b, f, r, rr;
    rst_n = 1'b0; grant = 1'b0; hold = 1'b0; gnt_delay = 1;
    repeat (3) @(negedge clk);
    chk("R1 req in reset", int'(req), 0);
    chk("R1 ready in reset", int'(ready), 0);
    chk("R1 own in reset", int'(own), 0);
    chk("R1 ras in reset", int'(ras_n), 1);
    chk("R1 cas in reset", int'(&cas_n), 1);
    rst_n = 1'b1;

    wait (rise_cnt >= 1);
    chk("R2 first request cycle", first_rise, PAUSE + 1);
    chk("R3 ready low in wake", int'(ready), 0);

    wait (ready_rises >= 1);
    chk("R3 ready up", int'(ready), 1);

    // R6: steady interval
    n = rise_cnt;
    wait (rise_cnt == n + 1); a = last_rise;
    wait (rise_cnt == n + 2); b = last_rise;
    chk("R6 interval one", b - a, INTV);
    wait (rise_cnt == n + 3);
    chk("R6 interval two", last_rise - b, INTV);

    // R10: grant with no request
    f = fall_cnt;
    wait (fall_cnt == f + 1);
    grant = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R10 own stays low", int'(own), 0);
      chk("R10 strobes high", int'(ras_n && (&cas_n)), 1);
    end
    grant = 1'b0;

    // R7: longer grant latency
    gnt_delay = 6;
    f = fall_cnt;
    wait (fall_cnt == f + 1);
    chk("R7 request width", req_width, 6 + 1 + CSR + RASL + RP);
    gnt_delay = 1;

    // R9: single misses below limit
    hold = 1'b1;
    n = rise_cnt;
    wait (rise_cnt == n + 1); r = last_rise;
    while (ncyc < r + INTV + 5) @(negedge clk);
    chk("R9 ready after one miss", int'(ready), 1);
    chk("R7 request held while starved", int'(req), 1);
    hold = 1'b0;
    f = fall_cnt;
    wait (fall_cnt == f + 1);
    hold = 1'b1;
    n = rise_cnt;
    wait (rise_cnt == n + 1); r = last_rise;
    while (ncyc < r + INTV + 5) @(negedge clk);
    chk("R9 count cleared by refresh", int'(ready), 1);
    hold = 1'b0;
    f = fall_cnt;
    wait (fall_cnt == f + 1);

    // R8: overdue budget broken
    hold = 1'b1;
    n = rise_cnt;
    wait (rise_cnt == n + 1); r = last_rise;
    a = ready_falls;
    wait (ready_falls == a + 1);
    chk("R8 ready drop cycle", ready_fall_cyc - r, MISS * INTV);
    chk("R8 request still pending", int'(req), 1);
    rr = ready_rises;
    hold = 1'b0;
    wait (ready_rises == rr + 1);
    chk("R8 ready restored", int'(ready), 1);
    repeat (5) @(negedge clk);
    chk("R7 all granted cycles seen", exp_q.size(), 0);
    finish_run();
  end

endmodule